// File: doc/BRIEF.md
# Converter Test Word Generator

This block sits in the output path of a 12-bit sampling converter. It either passes each live sample through unchanged, or it replaces the sample with a synthetic word. The synthetic words come from one of several sources: fixed levels, a bit checkerboard, a word that toggles between all ones and all zeros, a rising ramp, two pseudo-noise generators, and a player for two user-programmed words. A 4-bit selector chooses the source. A 2-bit field sets how the user words are played.

Sequence state advances only on sample-valid cycles, so the pattern follows the real sample cadence. Each result leaves a single output register one clock after its valid sample, with a matching valid flag. Two strobes reseed the long and the short noise generators, each on its own. Any change of either configuration field restarts every sequence from its initial state.

Top module: `adc_tpg_top`

## Requirements
- R1: While `rst_n` is low, `word_o` and `word_vld_o` are 0. All sequence state returns to its initial value. The remembered configuration becomes selector 0 with play field 0.
- R2: A cycle with `smp_vld_i` high raises `word_vld_o` at the next clock edge and loads `word_o` with that sample's result. A cycle with `smp_vld_i` low clears `word_vld_o` at the next edge and leaves `word_o` unchanged.
- R3: Selector 0000 and the unused codes 1001 to 1110 pass `smp_i` straight to `word_o`.
- R4: Selector 0001 gives 0x800, 0010 gives 0xFFF and 0011 gives 0x000.
- R5: Selector 0100 alternates 0xAAA and 0x555, starting with 0xAAA. Selector 0111 alternates 0xFFF and 0x000, starting with 0xFFF. Each valid sample flips the phase.
- R6: Selector 0101 outputs bits 22..11 of a 23-bit shift register seeded to all ones. The word is taken before the step. Each valid sample shifts the register left and inserts bit22 XOR bit17 at bit 0.
- R7: Selector 0110 outputs the 9-bit short register in bits 11..3, with bits 2..0 zero. The register is seeded to all ones. Each valid sample shifts it left and inserts bit8 XOR bit4.
- R8: A high `pn_long_rst_i` (or `pn_short_rst_i`) returns only that generator to all ones at the next edge. The word of a valid sample in the same cycle still uses the state held before the reseed.
- R9: Selector 1111 outputs a count that starts at 0, rises by 1 on each valid sample, and wraps from 0xFFF to 0.
- R10: Selector 1000 plays the user words A (`user_a_i`) and B (`user_b_i`) according to `play_i`. 00 gives A on every sample. 01 gives A, B, A, B and so on. 10 gives A once and then holds A. 11 gives A, then B, and then holds B.
- R11: When `{mode_i, play_i}` differs from its value in the previous cycle, all sequence state restarts. The restart covers phase, ramp count, user index and both noise registers. A valid sample in that same cycle already uses the initial state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sample clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| smp_vld_i | input | 1 | Sample-valid strobe |
| smp_i | input | 12 | Live converter sample |
| mode_i | input | 4 | Source selector |
| play_i | input | 2 | User-word playback control |
| pn_long_rst_i | input | 1 | Reseed strobe for the long noise generator |
| pn_short_rst_i | input | 1 | Reseed strobe for the short noise generator |
| user_a_i | input | 12 | User word A |
| user_b_i | input | 12 | User word B |
| word_o | output | 12 | Output word |
| word_vld_o | output | 1 | Output valid flag |

## Verification
Two functions can land in the same cycle. The first pair is a reseed strobe together with a valid sample while a noise mode is selected. The second pair is a change of selector or play field together with a valid sample. The bench provokes both on purpose: it pulses a reseed in the middle of a noise run, and it changes the play field while user playback is partway through. A behavioural model, run each clock, decides the expected word. In the reseed case, the word of that cycle keeps the old state and the following word starts from the seed. In the configuration-change case, the word of that cycle already comes from the restarted sequence.

// File: rtl/adc_tpg_pkg.sv
package adc_tpg_pkg;
    localparam int WORD_W = 12;

    typedef enum logic [3:0] {
        MODE_LIVE     = 4'h0,
        MODE_MID      = 4'h1,
        MODE_POS_FS   = 4'h2,
        MODE_NEG_FS   = 4'h3,
        MODE_CHECKER  = 4'h4,
        MODE_PN_LONG  = 4'h5,
        MODE_PN_SHORT = 4'h6,
        MODE_TOGGLE   = 4'h7,
        MODE_USER     = 4'h8,
        MODE_RAMP     = 4'hF
    } tpg_mode_e;

    typedef enum logic [1:0] {
        PLAY_REP_A    = 2'b00,
        PLAY_ALT      = 2'b01,
        PLAY_ONCE_A   = 2'b10,
        PLAY_ALT_ONCE = 2'b11
    } tpg_play_e;

    // Alternating-bit word: MSB set when phase is 0
    function automatic logic [WORD_W-1:0] checker_word(input logic phase);
        logic [WORD_W-1:0] w;
        for (int i = 0; i < WORD_W; i++) begin
            w[i] = ((i % 2) == 1) ^ phase;
        end
        return w;
    endfunction
endpackage

// File: rtl/adc_tpg_lfsr.sv
module adc_tpg_lfsr #(
    parameter int W      = 23,
    parameter int TAP_HI = 22,
    parameter int TAP_LO = 17,
    parameter int OUT_W  = 12
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             restart_i,
    input  logic             reseed_i,
    input  logic             adv_i,
    output logic [OUT_W-1:0] word_o
);
    localparam logic [W-1:0] SEED = '1;
    localparam int PAD = (OUT_W > W) ? (OUT_W - W) : 1;

    typedef struct packed {
        logic [W-1:0] st;
    } lfsr_state_t;

    lfsr_state_t state_d, state_q;
    logic [W-1:0] eff;

    always_comb begin
        eff     = restart_i ? SEED : state_q.st;
        state_d = state_q;
        if (reseed_i) begin
            state_d.st = SEED;
        end else if (adv_i) begin
            state_d.st = {eff[W-2:0], eff[TAP_HI] ^ eff[TAP_LO]};
        end else begin
            state_d.st = eff;
        end
    end

    generate
        if (W >= OUT_W) begin : g_wide
            assign word_o = eff[W-1 -: OUT_W];
        end else begin : g_narrow
            assign word_o = {eff, {PAD{1'b0}}};
        end
    endgenerate

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= '{st: SEED};
        else        state_q <= state_d;
    end
endmodule

// File: rtl/adc_tpg_seq.sv
module adc_tpg_seq #(
    parameter int RAMP_W = 12
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              restart_i,
    input  logic              adv_i,
    input  logic [1:0]        play_i,
    output logic              phase_o,
    output logic [RAMP_W-1:0] ramp_o,
    output logic              usel_o
);
    import adc_tpg_pkg::*;

    typedef struct packed {
        logic              phase;
        logic [RAMP_W-1:0] ramp;
        logic              uidx;
    } seq_state_t;

    seq_state_t state_d, state_q, eff;

    always_comb begin
        eff     = restart_i ? '0 : state_q;
        state_d = eff;
        if (adv_i) begin
            state_d.phase = ~eff.phase;
            state_d.ramp  = eff.ramp + RAMP_W'(1);
            case (play_i)
                PLAY_ALT:      state_d.uidx = ~eff.uidx;
                PLAY_ALT_ONCE: state_d.uidx = 1'b1;
                default:       state_d.uidx = 1'b0;
            endcase
        end
        phase_o = eff.phase;
        ramp_o  = eff.ramp;
        usel_o  = eff.uidx;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= '0;
        else        state_q <= state_d;
    end
endmodule

// File: rtl/adc_tpg_top.sv
module adc_tpg_top
    import adc_tpg_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              smp_vld_i,
    input  logic [WORD_W-1:0] smp_i,
    input  logic [3:0]        mode_i,
    input  logic [1:0]        play_i,
    input  logic              pn_long_rst_i,
    input  logic              pn_short_rst_i,
    input  logic [WORD_W-1:0] user_a_i,
    input  logic [WORD_W-1:0] user_b_i,
    output logic [WORD_W-1:0] word_o,
    output logic              word_vld_o
);
    localparam int CFG_W = 6;

    typedef struct packed {
        logic [CFG_W-1:0]  cfg;
        logic [WORD_W-1:0] word;
        logic              vld;
    } top_state_t;

    top_state_t state_d, state_q;
    logic restart;
    logic phase, usel;
    logic [WORD_W-1:0] ramp, pn_long, pn_short, sel;

    assign restart = ({mode_i, play_i} != state_q.cfg);

    adc_tpg_lfsr #(.W(23), .TAP_HI(22), .TAP_LO(17), .OUT_W(WORD_W)) u_pn_long (
        .clk(clk), .rst_n(rst_n), .restart_i(restart), .reseed_i(pn_long_rst_i),
        .adv_i(smp_vld_i), .word_o(pn_long)
    );

    adc_tpg_lfsr #(.W(9), .TAP_HI(8), .TAP_LO(4), .OUT_W(WORD_W)) u_pn_short (
        .clk(clk), .rst_n(rst_n), .restart_i(restart), .reseed_i(pn_short_rst_i),
        .adv_i(smp_vld_i), .word_o(pn_short)
    );

    adc_tpg_seq #(.RAMP_W(WORD_W)) u_seq (
        .clk(clk), .rst_n(rst_n), .restart_i(restart), .adv_i(smp_vld_i),
        .play_i(play_i), .phase_o(phase), .ramp_o(ramp), .usel_o(usel)
    );

    always_comb begin
        case (mode_i)
            MODE_MID:      sel = {1'b1, {(WORD_W-1){1'b0}}};
            MODE_POS_FS:   sel = '1;
            MODE_NEG_FS:   sel = '0;
            MODE_CHECKER:  sel = checker_word(phase);
            MODE_PN_LONG:  sel = pn_long;
            MODE_PN_SHORT: sel = pn_short;
            MODE_TOGGLE:   sel = phase ? '0 : '1;
            MODE_USER:     sel = usel ? user_b_i : user_a_i;
            MODE_RAMP:     sel = ramp;
            default:       sel = smp_i;
        endcase
    end

    always_comb begin
        state_d      = state_q;
        state_d.cfg  = {mode_i, play_i};
        state_d.vld  = smp_vld_i;
        if (smp_vld_i) state_d.word = sel;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= '0;
        else        state_q <= state_d;
    end

    assign word_o     = state_q.word;
    assign word_vld_o = state_q.vld;
endmodule

// File: rtl/adc_tpg_chk.sv
module adc_tpg_chk (
    input logic        clk,
    input logic        rst_n,
    input logic        smp_vld_i,
    input logic [11:0] smp_i,
    input logic [3:0]  mode_i,
    input logic [11:0] word_o,
    input logic        word_vld_o
);
    // R2
    vld_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        smp_vld_i |=> word_vld_o);
    // R2
    vld_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !smp_vld_i |=> (!word_vld_o && $stable(word_o)));
    // R3
    live_pass_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (smp_vld_i && (mode_i == 4'h0 || (mode_i >= 4'h9 && mode_i <= 4'hE)))
        |=> (word_o == $past(smp_i)));
    // R4
    fixed_level_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (smp_vld_i && mode_i == 4'h1) |=> (word_o == 12'h800));
    // R5
    checker_shape_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (smp_vld_i && mode_i == 4'h4) |=> (word_o == 12'hAAA || word_o == 12'h555));
    // R5
    toggle_shape_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (smp_vld_i && mode_i == 4'h7) |=> (word_o == 12'hFFF || word_o == 12'h000));
    // R7
    short_pad_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (smp_vld_i && mode_i == 4'h6) |=> (word_o[2:0] == 3'b000));
endmodule

bind adc_tpg_top adc_tpg_chk u_adc_tpg_chk (
    .clk(clk), .rst_n(rst_n), .smp_vld_i(smp_vld_i), .smp_i(smp_i),
    .mode_i(mode_i), .word_o(word_o), .word_vld_o(word_vld_o)
);

// File: tb/test_adc_tpg_top.sv
module test_adc_tpg_top;
    localparam int CLK_P = 10;

    logic clk = 1'b0;
    always #(CLK_P/2) clk = ~clk;

    logic        rst_n = 1'b0;
    logic        smp_vld_i = 1'b0;
    logic [11:0] smp_i = '0;
    logic [3:0]  mode_i = '0;
    logic [1:0]  play_i = '0;
    logic        pn_long_rst_i = 1'b0;
    logic        pn_short_rst_i = 1'b0;
    logic [11:0] user_a_i = 12'h3C5;
    logic [11:0] user_b_i = 12'hA19;
    logic [11:0] word_o;
    logic        word_vld_o;

    adc_tpg_top i_adc_tpg_top (
        .clk(clk), .rst_n(rst_n), .smp_vld_i(smp_vld_i), .smp_i(smp_i),
        .mode_i(mode_i), .play_i(play_i), .pn_long_rst_i(pn_long_rst_i),
        .pn_short_rst_i(pn_short_rst_i), .user_a_i(user_a_i), .user_b_i(user_b_i),
        .word_o(word_o), .word_vld_o(word_vld_o)
    );

    int checks = 0;
    int errors = 0;

    // behavioural reference state
    int unsigned m_long  = 32'h7F_FFFF;
    int unsigned m_short = 32'h1FF;
    int          m_phase = 0;
    int          m_ramp  = 0;
    int          m_uidx  = 0;
    int          m_cfg   = 0;
    int          exp_word = 0;
    int          exp_vld  = 0;
    string       exp_tag  = "R1";

    task automatic check(input string tag, input int act, input int exp, input string what);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s actual=%0h expected=%0h at %0t", tag, what, act, exp, $time);
        end
    endtask

    // Reference for one clock edge using the inputs currently applied
    task automatic model_edge();
        int cfg, w;
        cfg = {mode_i, play_i};
        exp_tag = "R3";
        if (cfg != m_cfg) begin
            m_long = 32'h7F_FFFF; m_short = 32'h1FF;
            m_phase = 0; m_ramp = 0; m_uidx = 0;
        end
        case (mode_i)
            4'h1: begin w = 12'h800; exp_tag = "R4"; end
            4'h2: begin w = 12'hFFF; exp_tag = "R4"; end
            4'h3: begin w = 12'h000; exp_tag = "R4"; end
            4'h4: begin w = m_phase ? 12'h555 : 12'hAAA; exp_tag = "R5"; end
            4'h5: begin w = (m_long >> 11) & 12'hFFF; exp_tag = "R6"; end
            4'h6: begin w = (m_short << 3) & 12'hFFF; exp_tag = "R7"; end
            4'h7: begin w = m_phase ? 12'h000 : 12'hFFF; exp_tag = "R5"; end
            4'h8: begin w = m_uidx ? user_b_i : user_a_i; exp_tag = "R10"; end
            4'hF: begin w = m_ramp; exp_tag = "R9"; end
            default: w = smp_i;
        endcase
        if (cfg != m_cfg) exp_tag = "R11";
        if (pn_long_rst_i || pn_short_rst_i) exp_tag = "R8";
        if (smp_vld_i) begin
            exp_word = w;
            exp_vld  = 1;
            m_long  = ((m_long << 1) | (((m_long >> 22) ^ (m_long >> 17)) & 1)) & 32'h7F_FFFF;
            m_short = ((m_short << 1) | (((m_short >> 8) ^ (m_short >> 4)) & 1)) & 32'h1FF;
            m_phase = 1 - m_phase;
            m_ramp  = (m_ramp + 1) % 4096;
            case (play_i)
                2'b01:   m_uidx = 1 - m_uidx;
                2'b11:   m_uidx = 1;
                default: m_uidx = 0;
            endcase
        end else begin
            exp_vld = 0;
            exp_tag = "R2";
        end
        if (pn_long_rst_i)  m_long  = 32'h7F_FFFF;
        if (pn_short_rst_i) m_short = 32'h1FF;
        m_cfg = cfg;
    endtask

    // Apply inputs at a falling edge, run one clock, compare at the next falling edge
    task automatic cyc(input bit v, input logic [3:0] md, input logic [1:0] pl,
                       input bit lr = 0, input bit sr = 0);
        smp_vld_i = v; smp_i = 12'($urandom); mode_i = md; play_i = pl;
        pn_long_rst_i = lr; pn_short_rst_i = sr;
        model_edge();
        @(posedge clk);
        @(negedge clk);
        check(exp_tag, int'(word_vld_o), exp_vld, "valid");
        check(exp_tag, int'(word_o), exp_word, "word");
    endtask

    task automatic run(input int n, input logic [3:0] md, input logic [1:0] pl, input bit gaps);
        for (int i = 0; i < n; i++) cyc(gaps ? (($urandom % 4) != 0) : 1'b1, md, pl);
    endtask

    initial begin
        #(CLK_P * 200000);
        errors++;
        $display("FAIL watchdog expired actual=running expected=finished");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        // R1: outputs cleared during reset
        check("R1", int'(word_o), 0, "reset word");
        check("R1", int'(word_vld_o), 0, "reset valid");
        rst_n = 1'b1;
        // R2, R3: live data with gaps in the valid strobe
        run(30, 4'h0, 2'b00, 1);
        // R3: unused selector codes behave as live
        for (int c = 9; c <= 14; c++) run(4, 4'(c), 2'b00, 1);
        // R4: fixed levels
        run(4, 4'h1, 2'b00, 0);
        run(4, 4'h2, 2'b00, 0);
        run(4, 4'h3, 2'b00, 1);
        // R5: checkerboard and toggle, with gaps holding the phase
        run(12, 4'h4, 2'b00, 1);
        run(12, 4'h7, 2'b00, 1);
        // R6 and R8: long noise, reseed coinciding with a valid sample
        run(40, 4'h5, 2'b00, 0);
        cyc(1, 4'h5, 2'b00, 1, 0);
        run(10, 4'h5, 2'b00, 1);
        cyc(1, 4'h5, 2'b00, 0, 1);   // R8: short strobe leaves long sequence alone
        run(10, 4'h5, 2'b00, 0);
        // R7 and R8: short noise past its period, reseed without a sample
        run(600, 4'h6, 2'b00, 0);
        cyc(0, 4'h6, 2'b00, 0, 1);
        run(10, 4'h6, 2'b00, 0);
        cyc(1, 4'h6, 2'b00, 1, 0);   // R8: long strobe leaves short sequence alone
        run(10, 4'h6, 2'b00, 0);
        // R9: ramp through wrap
        run(4200, 4'hF, 2'b00, 0);
        // R10: every play setting, R11: play change mid-sequence
        run(6, 4'h8, 2'b00, 1);
        run(7, 4'h8, 2'b01, 1);
        run(5, 4'h8, 2'b10, 0);
        run(6, 4'h8, 2'b11, 1);
        run(3, 4'h8, 2'b01, 0);
        run(3, 4'h8, 2'b11, 0);
        // R11: selector change mid-ramp and mid-checkerboard
        run(9, 4'hF, 2'b00, 0);
        run(3, 4'h4, 2'b00, 0);
        run(5, 4'hF, 2'b00, 0);
        run(5, 4'h0, 2'b00, 0);
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule